// File: doc/BRIEF.md
# SPI Interrupt Event Status Unit

This unit gathers the three interrupt events of an SPI controller (transfer complete, receive data ready and receive overflow) into a sticky raw event register. It gates that register with enable bits taken from the controller's control register to form a masked view, and it drives one interrupt line. A sequencer elsewhere in the controller produces the events as single-cycle pulses. Software sees the unit through a simple word-addressed register bus. It reads the raw and masked views, and it acknowledges events by writing ones to a clear register.

The interrupt-enable bits sit in control register bits 6:4, and the unit receives that three-bit slice. Their order differs from the order of the status bits they gate, so the unit remaps them before masking. Bus writes to the read-only views, and to the controller status word address, do not reach the event state. Event pulses and clear writes are applied on the same clock edge. When both hit the same bit, the event is kept, so an event that arrives while software is acknowledging an earlier one is not lost.

Top module: `spiIrqStatus`

## Requirements
- R1: After reset the raw event register is 0, the interrupt output is low and the clear register reads back 0.
- R2: A one-cycle pulse on `evtDone`, `evtRxRdy` or `evtOvf` sets raw bit 0, 1 or 2 respectively on the next clock edge. The bit then stays set until it is cleared. Reading address 9 returns the raw bits in data bits 2:0, with zeros above them.
- R3: Reading address 8 returns the masked view in bits 2:0, with zeros above. Masked bit 0 is raw bit 0 AND `ctrlIntField[1]` (control bit 5). Masked bit 1 is raw bit 1 AND `ctrlIntField[0]` (control bit 4). Masked bit 2 is raw bit 2 AND `ctrlIntField[2]` (control bit 6).
- R4: `irqOut` is high exactly when at least one masked bit is 1.
- R5: A bus write to address 3 clears every raw bit n (n = 0..2) for which data bit n is 1. Raw bits whose data bit is 0 keep their value.
- R6: Bus writes to address 2 (controller status), 8 (masked view) or 9 (raw view) leave the raw register unchanged, whatever the data.
- R7: When an event pulse and a clear of the same raw bit occur in the same cycle, the bit ends up set.
- R8: The masked view and `irqOut` follow changes of the enable slice and of the raw register in the same cycle, with no storage of their own. Disabling every source drops `irqOut` without altering the raw bits. Clearing the last enabled raw bit releases `irqOut`.
- R9: Reading address 3 returns the last full word written there. Reading any address other than 3, 8 or 9 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtDone | input | 1 | Transfer-complete event pulse |
| evtRxRdy | input | 1 | Receive-ready event pulse |
| evtOvf | input | 1 | Receive-overflow event pulse |
| ctrlIntField | input | 3 | Control register bits 6:4 (interrupt enables) |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 4 | Bus write word address |
| wrData | input | 32 | Bus write data |
| rdAddr | input | 4 | Bus read word address |
| rdData | output | 32 | Bus read data (combinational) |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench builds the unit with its default parameters: a 4-bit word address, a 32-bit data word, the clear, masked and raw registers at addresses 3, 8 and 9, and the enable slice ordered as in the control register. With these values the bench can drive each enable bit on its own and so expose any error in the remapping. It can also write all-ones words to every read-only address, and it can line up a clear and an event on the same edge to observe which one wins. Because the clear register stores the full 32-bit word, the bench can also check readback of the upper bits, which have no effect on the event state.

// File: rtl/spiIrqPkg.sv
package spiIrqPkg;

  // number of interrupt event sources handled by the unit
  localparam int NUM_EVT = 3;

  // event bit positions in the raw and masked views
  localparam int EVT_DONE = 0;
  localparam int EVT_RXRDY = 1;
  localparam int EVT_OVF = 2;

  // read source selected by the control module
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_RAW   = 2'd1,
    RD_MASK  = 2'd2,
    RD_CLEAR = 2'd3
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_EVT-1:0] clrBits;   // per-bit clear request this cycle
    logic               clrWrite;  // clear register written this cycle
    rdSel_e             rdSel;     // source of read data
  } ctlStrobe_t;

endpackage

// File: rtl/spiIrqCtl.sv
module spiIrqCtl
  import spiIrqPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CLR_ADDR  = 3,
  parameter int MASK_ADDR = 8,
  parameter int RAW_ADDR  = 9
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(RAW_ADDR);

  logic hitClear;

  // Only the clear register is writable here. Every other address,
  // including the read-only views, produces no strobe at all.
  always_comb begin
    hitClear = wrEn && (wrAddr == CLR_A);
  end

  always_comb begin
    strobe.clrWrite = hitClear;
    strobe.clrBits  = hitClear ? wrData[NUM_EVT-1:0] : '0;
    unique case (rdAddr)
      RAW_A:   strobe.rdSel = RD_RAW;
      MASK_A:  strobe.rdSel = RD_MASK;
      CLR_A:   strobe.rdSel = RD_CLEAR;
      default: strobe.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/spiIrqData.sv
module spiIrqData
  import spiIrqPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int EN_DONE_IX = 1,  // slice index of transfer-done enable
  parameter int EN_RX_IX   = 0,  // slice index of receive-ready enable
  parameter int EN_OVF_IX  = 2   // slice index of overflow enable
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic [NUM_EVT-1:0] ctrlIntField,
  input  logic [DATA_W-1:0]  wrData,
  input  ctlStrobe_t         strobe,
  output logic [NUM_EVT-1:0] rawQ,
  output logic [NUM_EVT-1:0] maskedV,
  output logic               irqOut,
  output logic [DATA_W-1:0]  rdData
);

  // event slot -> index in the control enable slice
  localparam int EN_MAP [NUM_EVT] = '{EN_DONE_IX, EN_RX_IX, EN_OVF_IX};

  logic [NUM_EVT-1:0] enRemap;
  logic [DATA_W-1:0]  clrShadow;

  // one sticky cell per event: a set beats a simultaneous clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rawQ[i] <= 1'b0;
      end else if (evtVec[i]) begin
        rawQ[i] <= 1'b1;
      end else if (strobe.clrBits[i]) begin
        rawQ[i] <= 1'b0;
      end
    end
    assign enRemap[i] = ctrlIntField[EN_MAP[i]];
  end

  // last word written to the clear register, for readback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrShadow <= '0;
    end else if (strobe.clrWrite) begin
      clrShadow <= wrData;
    end
  end

  // masked view and interrupt are pure functions of current state
  always_comb begin
    maskedV = rawQ & enRemap;
    irqOut  = |maskedV;
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_RAW:   rdData[NUM_EVT-1:0] = rawQ;
      RD_MASK:  rdData[NUM_EVT-1:0] = maskedV;
      RD_CLEAR: rdData = clrShadow;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/spiIrqStatus.sv
module spiIrqStatus
  import spiIrqPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STAT_ADDR  = 2,
  parameter int CLR_ADDR   = 3,
  parameter int MASK_ADDR  = 8,
  parameter int RAW_ADDR   = 9,
  parameter int EN_DONE_IX = 1,
  parameter int EN_RX_IX   = 0,
  parameter int EN_OVF_IX  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtDone,
  input  logic              evtRxRdy,
  input  logic              evtOvf,
  input  logic [2:0]        ctrlIntField,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] rawQ;
  logic [NUM_EVT-1:0] maskedV;
  ctlStrobe_t         strobe;

  assign evtVec[EVT_DONE]  = evtDone;
  assign evtVec[EVT_RXRDY] = evtRxRdy;
  assign evtVec[EVT_OVF]   = evtOvf;

  spiIrqCtl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLR_ADDR (CLR_ADDR),
    .MASK_ADDR(MASK_ADDR),
    .RAW_ADDR (RAW_ADDR)
  ) u_ctl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .strobe(strobe)
  );

  spiIrqData #(
    .DATA_W    (DATA_W),
    .EN_DONE_IX(EN_DONE_IX),
    .EN_RX_IX  (EN_RX_IX),
    .EN_OVF_IX (EN_OVF_IX)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .evtVec      (evtVec),
    .ctrlIntField(ctrlIntField),
    .wrData      (wrData),
    .strobe      (strobe),
    .rawQ        (rawQ),
    .maskedV     (maskedV),
    .irqOut      (irqOut),
    .rdData      (rdData)
  );

endmodule

// File: rtl/spiIrqChk.sv
module spiIrqChk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STAT_ADDR  = 2,
  parameter int CLR_ADDR   = 3,
  parameter int MASK_ADDR  = 8,
  parameter int RAW_ADDR   = 9,
  parameter int EN_DONE_IX = 1,
  parameter int EN_RX_IX   = 0,
  parameter int EN_OVF_IX  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        evtVec,
  input logic [2:0]        rawQ,
  input logic [2:0]        ctrlIntField,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut
);

  logic [2:0] expEn;
  logic       roWrite;
  assign expEn   = {ctrlIntField[EN_OVF_IX], ctrlIntField[EN_RX_IX], ctrlIntField[EN_DONE_IX]};
  assign roWrite = wrEn && (wrAddr == ADDR_W'(STAT_ADDR) || wrAddr == ADDR_W'(MASK_ADDR)
                            || wrAddr == ADDR_W'(RAW_ADDR));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rawQ == 3'b000 && !irqOut));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawQ & ~$past(rawQ) & ~$past(evtVec)) == 3'b000));

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((rawQ & $past(evtVec)) == $past(evtVec)));

  // R3
  masked_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(MASK_ADDR)) |-> (rdData == DATA_W'(rawQ & expEn)));

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(rawQ & expEn)));

  // R5
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(CLR_ADDR)) |=>
      ((rawQ & $past(wrData[2:0]) & ~$past(evtVec)) == 3'b000));

  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (roWrite && evtVec == 3'b000) |=> $stable(rawQ));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(CLR_ADDR) && |(evtVec & wrData[2:0])) |=>
      ((rawQ & $past(evtVec)) == $past(evtVec)));

endmodule

bind spiIrqStatus spiIrqChk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .STAT_ADDR (STAT_ADDR),
  .CLR_ADDR  (CLR_ADDR),
  .MASK_ADDR (MASK_ADDR),
  .RAW_ADDR  (RAW_ADDR),
  .EN_DONE_IX(EN_DONE_IX),
  .EN_RX_IX  (EN_RX_IX),
  .EN_OVF_IX (EN_OVF_IX)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .evtVec      (evtVec),
  .rawQ        (rawQ),
  .ctrlIntField(ctrlIntField),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .irqOut      (irqOut)
);

// File: tb/sim_spiIrqStatus.sv
module sim_spiIrqStatus;

  localparam int A_STAT = 2;
  localparam int A_CLR  = 3;
  localparam int A_MASK = 8;
  localparam int A_RAW  = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtDone = 1'b0, evtRxRdy = 1'b0, evtOvf = 1'b0;
  logic [2:0]  ctrlIntField = 3'b000;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = 4'd0;
  logic [31:0] wrData = 32'd0;
  logic [3:0]  rdAddr = 4'd0;
  logic [31:0] rdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spiIrqStatus u0 (
    .clk(clk), .rstN(rstN),
    .evtDone(evtDone), .evtRxRdy(evtRxRdy), .evtOvf(evtOvf),
    .ctrlIntField(ctrlIntField),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input int addr, output logic [31:0] val);
    rdAddr = 4'(addr);
    #1;
    val = rdData;
  endtask

  // drive event bits {ovf,rx,done} for one cycle; optionally a clear write with it
  task automatic cycle(input logic [2:0] evt, input bit doWr, input int addr, input logic [31:0] data);
    @(negedge clk);
    {evtOvf, evtRxRdy, evtDone} = evt;
    wrEn = doWr;
    wrAddr = 4'(addr);
    wrData = data;
    @(negedge clk);
    {evtOvf, evtRxRdy, evtDone} = 3'b000;
    wrEn = 1'b0;
  endtask

  task automatic clearAll();
    cycle(3'b000, 1'b1, A_CLR, 32'h7);
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(A_RAW, v);  check("R1 raw", v, 32'h0);
    readReg(A_CLR, v);  check("R1 clrreg", v, 32'h0);
    check("R1 irq", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic testSetAndClear();
    logic [31:0] v;
    ctrlIntField = 3'b111;
    cycle(3'b001, 1'b0, 0, 0);
    readReg(A_RAW, v);  check("R2 done bit0", v, 32'h1);
    check("R4 irq on", {31'd0, irqOut}, 32'h1);
    cycle(3'b100, 1'b0, 0, 0);
    readReg(A_RAW, v);  check("R2 ovf bit2 sticky", v, 32'h5);
    cycle(3'b000, 1'b0, 0, 0);
    readReg(A_RAW, v);  check("R2 hold", v, 32'h5);
    clearAll();
    readReg(A_RAW, v);  check("R5 clear all", v, 32'h0);
    check("R8 irq release", {31'd0, irqOut}, 32'h0);
    cycle(3'b010, 1'b0, 0, 0);
    readReg(A_RAW, v);  check("R2 rx bit1", v, 32'h2);
    clearAll();
  endtask

  task automatic testRemap();
    logic [31:0] v;
    cycle(3'b111, 1'b0, 0, 0);
    @(negedge clk);
    ctrlIntField = 3'b010;
    readReg(A_MASK, v); check("R3 ctrl5->bit0", v, 32'h1);
    check("R4 irq one", {31'd0, irqOut}, 32'h1);
    ctrlIntField = 3'b001;
    readReg(A_MASK, v); check("R3 ctrl4->bit1", v, 32'h2);
    ctrlIntField = 3'b100;
    readReg(A_MASK, v); check("R3 ctrl6->bit2", v, 32'h4);
    ctrlIntField = 3'b000;
    readReg(A_MASK, v); check("R8 masked off", v, 32'h0);
    check("R8 irq off", {31'd0, irqOut}, 32'h0);
    readReg(A_RAW, v);  check("R8 raw kept", v, 32'h7);
    // only overflow enabled, only done pending -> no interrupt
    clearAll();
    cycle(3'b001, 1'b0, 0, 0);
    ctrlIntField = 3'b100;
    #1;
    check("R4 irq gated", {31'd0, irqOut}, 32'h0);
    ctrlIntField = 3'b111;
    clearAll();
  endtask

  task automatic testPartialClear();
    logic [31:0] v;
    cycle(3'b111, 1'b0, 0, 0);
    cycle(3'b000, 1'b1, A_CLR, 32'h2);
    readReg(A_RAW, v);  check("R5 clear bit1 only", v, 32'h5);
    cycle(3'b000, 1'b1, A_CLR, 32'hFFFF_FFF8);
    readReg(A_RAW, v);  check("R5 zero bits keep", v, 32'h5);
    readReg(A_CLR, v);  check("R9 clr readback", v, 32'hFFFF_FFF8);
    cycle(3'b000, 1'b1, A_CLR, 32'h5);
    readReg(A_RAW, v);  check("R5 clear rest", v, 32'h0);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    cycle(3'b011, 1'b0, 0, 0);
    cycle(3'b000, 1'b1, A_RAW, 32'hFFFF_FFFF);
    readReg(A_RAW, v);  check("R6 raw write", v, 32'h3);
    cycle(3'b000, 1'b1, A_MASK, 32'hFFFF_FFFF);
    readReg(A_RAW, v);  check("R6 mask write", v, 32'h3);
    cycle(3'b000, 1'b1, A_STAT, 32'hFFFF_FFFF);
    readReg(A_RAW, v);  check("R6 status write", v, 32'h3);
    cycle(3'b000, 1'b1, A_RAW, 32'h0);
    readReg(A_RAW, v);  check("R6 raw write zero", v, 32'h3);
    readReg(A_CLR, v);  check("R6 clr untouched", v, 32'h5);
    clearAll();
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    cycle(3'b001, 1'b1, A_CLR, 32'h1);
    readReg(A_RAW, v);  check("R7 done set wins", v, 32'h1);
    cycle(3'b100, 1'b1, A_CLR, 32'h7);
    readReg(A_RAW, v);  check("R7 ovf wins, others clear", v, 32'h4);
    clearAll();
  endtask

  task automatic testReadMux();
    logic [31:0] v;
    cycle(3'b111, 1'b0, 0, 0);
    readReg(0, v);      check("R9 addr0 zero", v, 32'h0);
    readReg(A_STAT, v); check("R9 addr2 zero", v, 32'h0);
    readReg(15, v);     check("R9 addr15 zero", v, 32'h0);
    clearAll();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetAndClear();
    testRemap();
    testPartialClear();
    testReadOnly();
    testSetWins();
    testReadMux();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule